// File: doc/BRIEF.md
# Lite UART Register and FIFO Front End

This block sits between a simple 32-bit memory-mapped slave bus and the serial engine of a small UART. It decodes four word locations in a 16-byte window: a data port that pops received bytes, a data port that pushes bytes to be sent, one combined status word and one control word. Behind the transmit port sits a byte FIFO whose head is offered to the serial transmitter as a valid/take stream. Received bytes arrive from the serial receiver as a one-cycle push strobe and land in a second byte FIFO.

The serial engine also reports framing and parity faults as one-cycle strobes. The block records them, together with receive overflow, as sticky flags that a status read returns and then clears. Software can flush either FIFO and gate a single interrupt line through the control word. The enable state can be read back in the status word. The interrupt is a one-cycle pulse raised when received data first appears or when the transmit queue drains.

Bus accesses complete in the cycle they are presented. Read data is combinational from the address, and every side effect takes place on the clock edge that ends the access.

Top module: `lite_uart_regs`

## Requirements
- R1: Address bits 3:2 select the word: 0 receive data, 1 transmit data, 2 status, 3 control. Address bits 1:0 are ignored.
- R2: Status bits are: 0 receive data valid, 1 receive FIFO full, 2 transmit FIFO empty, 3 transmit FIFO full, 4 interrupt enabled, 5 overrun, 6 frame error, 7 parity error. Bits 31:8 read zero. After reset the status reads 0x04.
- R3: A read of word 0 returns the oldest received byte in bits 7:0, with zeros above, and removes that byte from the FIFO. When the receive FIFO is empty, the read returns zero and has no effect.
- R4: A write to word 1 queues bits 7:0; upper bits are ignored. Queued bytes appear on `txByte` with `txValid` high, in write order. Each cycle with `txTake` high removes one byte.
- R5: Each FIFO holds 16 bytes. A write to word 1 while the transmit FIFO is full is discarded.
- R6: A receive push while the receive FIFO is full is dropped and sets the overrun flag.
- R7: `frameErr` and `parityErr` pulses set sticky flags. A status read returns the flags and clears them on the same edge. A fault that arrives in the same cycle as the read stays set for the next read.
- R8: Writing control bit 0 flushes the transmit FIFO, so status then shows transmit empty. Writing control bit 1 flushes the receive FIFO. These bits act once and are not stored.
- R9: Every control write loads bit 4 as the interrupt enable, and status bit 4 reflects that enable. Writing zero to control disables interrupts.
- R10: While interrupts are enabled, `irq` is high for exactly the first cycle in which receive data is valid after being absent, or in which the transmit FIFO is empty after being non-empty. It stays low while interrupts are disabled.
- R11: Reads of word 1 and word 3 return zero and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte address inside the 16-byte window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| txByte | output | 8 | Head of transmit FIFO |
| txValid | output | 1 | Transmit FIFO not empty |
| txTake | input | 1 | Serial transmitter consumes the head byte |
| rxByte | input | 8 | Byte from serial receiver |
| rxPush | input | 1 | rxByte valid for one cycle |
| frameErr | input | 1 | Framing fault strobe from receiver |
| parityErr | input | 1 | Parity fault strobe from receiver |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that at most one bus access is presented per cycle and that `txTake` and `rxPush` are one-cycle strobes synchronous to `clk`. They also assume `txTake` may be asserted while the transmit FIFO is empty, and that case is ignored. The stimulus meets these assumptions: every bus access is a single-cycle select followed by an idle cycle, and each serial strobe is raised for exactly one clock edge. `txTake` is only raised once the bench has seen `txValid`.

// File: rtl/lite_uart_pkg.sv
package lite_uart_pkg;
  // word indices selected by address bits 3:2
  localparam logic [1:0] WORD_RX   = 2'd0;
  localparam logic [1:0] WORD_TX   = 2'd1;
  localparam logic [1:0] WORD_STAT = 2'd2;
  localparam logic [1:0] WORD_CTRL = 2'd3;

  // control word bit positions
  localparam int CTRL_TXFLUSH = 0;
  localparam int CTRL_RXFLUSH = 1;
  localparam int CTRL_IE      = 4;

  // strobes from register control to datapath
  typedef struct packed {
    logic rxPop;
    logic txPush;
    logic txFlush;
    logic rxFlush;
    logic ieLoad;
    logic ieValue;
    logic errClear;
  } regStrobes_t;
endpackage

// File: rtl/lite_fifo.sv
module lite_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic [LW-1:0]    level
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [LW-1:0] count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == LW'(DEPTH));
  assign level  = count;
  assign doPush = push & ~full;
  assign doPop  = pop & ~empty;
  assign rdata  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/lite_reg_ctrl.sv
module lite_reg_ctrl
  import lite_uart_pkg::*;
(
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  input  logic [7:0]  statusByte,
  input  logic [7:0]  rxHead,
  output regStrobes_t strobes,
  output logic [31:0] busRdata
);
  logic [1:0] word;
  logic rdAcc, wrAcc;
  logic unusedBits;

  assign word  = busAddr[3:2];
  assign rdAcc = busSel & ~busWrite;
  assign wrAcc = busSel & busWrite;
  assign unusedBits = ^{busAddr[1:0], busWdata[31:5], busWdata[3:2]};

  always_comb begin
    strobes          = '0;
    strobes.rxPop    = rdAcc && (word == WORD_RX);
    strobes.errClear = rdAcc && (word == WORD_STAT);
    strobes.txPush   = wrAcc && (word == WORD_TX);
    strobes.ieLoad   = wrAcc && (word == WORD_CTRL);
    strobes.ieValue  = busWdata[CTRL_IE];
    strobes.txFlush  = strobes.ieLoad && busWdata[CTRL_TXFLUSH];
    strobes.rxFlush  = strobes.ieLoad && busWdata[CTRL_RXFLUSH];
  end

  always_comb begin
    busRdata = '0;
    if (rdAcc) begin
      case (word)
        WORD_RX:   busRdata = statusByte[0] ? {24'd0, rxHead} : 32'd0;
        WORD_STAT: busRdata = {24'd0, statusByte};
        default:   busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lite_datapath.sv
module lite_datapath
  import lite_uart_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  regStrobes_t   strobes,
  input  logic [7:0]    wrByte,
  input  logic          txTake,
  input  logic [7:0]    rxByte,
  input  logic          rxPush,
  input  logic          frameErr,
  input  logic          parityErr,
  output logic [7:0]    statusByte,
  output logic [7:0]    rxHead,
  output logic [7:0]    txByte,
  output logic          txValid,
  output logic          irq,
  output logic [LW-1:0] txLevel,
  output logic [LW-1:0] rxLevel
);
  logic txEmpty, txFull, rxEmpty, rxFull;
  logic ovrFlag, frmFlag, parFlag, ieQ;
  logic rxValidQ, txEmptyQ;

  lite_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(strobes.txFlush),
    .push(strobes.txPush), .pop(txTake), .wdata(wrByte),
    .rdata(txByte), .empty(txEmpty), .full(txFull), .level(txLevel)
  );

  lite_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(strobes.rxFlush),
    .push(rxPush), .pop(strobes.rxPop), .wdata(rxByte),
    .rdata(rxHead), .empty(rxEmpty), .full(rxFull), .level(rxLevel)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovrFlag  <= 1'b0;
      frmFlag  <= 1'b0;
      parFlag  <= 1'b0;
      ieQ      <= 1'b0;
      rxValidQ <= 1'b0;
      txEmptyQ <= 1'b1;
    end else begin
      ovrFlag  <= (ovrFlag & ~strobes.errClear) | (rxPush & rxFull);
      frmFlag  <= (frmFlag & ~strobes.errClear) | frameErr;
      parFlag  <= (parFlag & ~strobes.errClear) | parityErr;
      if (strobes.ieLoad) ieQ <= strobes.ieValue;
      rxValidQ <= ~rxEmpty;
      txEmptyQ <= txEmpty;
    end
  end

  assign txValid    = ~txEmpty;
  assign statusByte = {parFlag, frmFlag, ovrFlag, ieQ, txFull, txEmpty, rxFull, ~rxEmpty};
  assign irq        = ieQ & ((~rxEmpty & ~rxValidQ) | (txEmpty & ~txEmptyQ));
endmodule

// File: rtl/lite_uart_regs.sv
module lite_uart_regs
  import lite_uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LW = $clog2(FIFO_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic [7:0]  txByte,
  output logic        txValid,
  input  logic        txTake,
  input  logic [7:0]  rxByte,
  input  logic        rxPush,
  input  logic        frameErr,
  input  logic        parityErr,
  output logic        irq
);
  regStrobes_t strobes;
  logic [7:0] statusByte, rxHead;
  logic [LW-1:0] txLevel, rxLevel;

  lite_reg_ctrl u_ctrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .statusByte(statusByte), .rxHead(rxHead),
    .strobes(strobes), .busRdata(busRdata)
  );

  lite_datapath #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrByte(busWdata[7:0]),
    .txTake(txTake), .rxByte(rxByte), .rxPush(rxPush),
    .frameErr(frameErr), .parityErr(parityErr),
    .statusByte(statusByte), .rxHead(rxHead), .txByte(txByte),
    .txValid(txValid), .irq(irq), .txLevel(txLevel), .rxLevel(rxLevel)
  );
endmodule

// File: rtl/lite_uart_regs_chk.sv
module lite_uart_regs_chk #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          busSel,
  input logic          busWrite,
  input logic [3:0]    busAddr,
  input logic [31:0]   busWdata,
  input logic [31:0]   busRdata,
  input logic          txTake,
  input logic          rxPush,
  input logic          irq,
  input logic [LW-1:0] txLevel,
  input logic [LW-1:0] rxLevel
);
  logic ieShadow;
  logic ctrlWr, txWr, rxRd, statRd;

  assign ctrlWr = busSel && busWrite && (busAddr[3:2] == 2'd3);
  assign txWr   = busSel && busWrite && (busAddr[3:2] == 2'd1);
  assign rxRd   = busSel && !busWrite && (busAddr[3:2] == 2'd0);
  assign statRd = busSel && !busWrite && (busAddr[3:2] == 2'd2);

  always_ff @(posedge clk) begin
    if (!rstN) ieShadow <= 1'b0;
    else if (ctrlWr) ieShadow <= busWdata[4];
  end

  // R5
  tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel == LW'(DEPTH) && txWr && !txTake) |=> (txLevel == LW'(DEPTH)));

  // R6
  rx_full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == LW'(DEPTH) && rxPush && !busSel) |=> (rxLevel == LW'(DEPTH)));

  // R8
  tx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busWdata[0]) |=> (txLevel == '0));

  // R9
  ie_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    statRd |-> (busRdata[4] == ieShadow));

  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ieShadow);

  // R11
  zero_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busAddr[2]) |-> (busRdata == 32'd0));

  // R3
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxRd && rxLevel != '0 && !rxPush) |=> (rxLevel == $past(rxLevel) - 1'b1));
endmodule

bind lite_uart_regs lite_uart_regs_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .txTake(txTake), .rxPush(rxPush), .irq(irq),
  .txLevel(txLevel), .rxLevel(rxLevel)
);

// File: tb/lite_uart_regs_bench.sv
module lite_uart_regs_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0] txByte;
  logic txValid;
  logic txTake = 1'b0;
  logic [7:0] rxByte = '0;
  logic rxPush = 1'b0, frameErr = 1'b0, parityErr = 1'b0;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lite_uart_regs u_lite_uart_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txByte(txByte), .txValid(txValid), .txTake(txTake),
    .rxByte(rxByte), .rxPush(rxPush), .frameErr(frameErr),
    .parityErr(parityErr), .irq(irq)
  );

  // vector: {isWrite, addr[3:0], data[31:0], expected[31:0]}
  localparam int NV = 12;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 4'h8, 32'h0,   32'h04},
    {1'b0, 4'hB, 32'h0,   32'h04},
    {1'b1, 4'hC, 32'h10,  32'h0},
    {1'b0, 4'h8, 32'h0,   32'h14},
    {1'b1, 4'h4, 32'h1A5, 32'h0},
    {1'b0, 4'h8, 32'h0,   32'h10},
    {1'b0, 4'h4, 32'h0,   32'h0},
    {1'b0, 4'hC, 32'h0,   32'h0},
    {1'b1, 4'hC, 32'h11,  32'h0},
    {1'b0, 4'h8, 32'h0,   32'h14},
    {1'b1, 4'hC, 32'h0,   32'h0},
    {1'b0, 4'h8, 32'h0,   32'h04}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #3 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic rxSend(input logic [7:0] b, output logic irqSeen);
    @(negedge clk);
    rxPush = 1'b1; rxByte = b;
    @(negedge clk);
    rxPush = 1'b0;
    irqSeen = irq;
  endtask

  task automatic txPop(output logic irqSeen);
    @(negedge clk);
    txTake = 1'b1;
    @(negedge clk);
    txTake = 1'b0;
    irqSeen = irq;
  endtask

  initial begin
    logic [31:0] d;
    logic ir;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 reset irq", {31'd0, irq}, 32'd0);
    check("R4 reset txValid", {31'd0, txValid}, 32'd0);

    // R1 R2 R8 R9 R11 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][68]) busWr(VEC[i][67:64], VEC[i][63:32]);
      else begin
        busRd(VEC[i][67:64], d);
        check($sformatf("R1 R2 R8 R9 R11 table step %0d", i), d, VEC[i][31:0]);
      end
    end

    // R4 ordering and R10 tx-drain pulse
    busWr(4'hC, 32'h10);
    busWr(4'h4, 32'hFFFF_FF11);
    busWr(4'h4, 32'h22);
    busWr(4'h4, 32'h33);
    check("R4 txValid", {31'd0, txValid}, 32'd1);
    check("R4 head 0", {24'd0, txByte}, 32'h11);
    txPop(ir);
    check("R4 head 1", {24'd0, txByte}, 32'h22);
    check("R10 no irq while nonempty", {31'd0, ir}, 32'd0);
    txPop(ir);
    check("R4 head 2", {24'd0, txByte}, 32'h33);
    txPop(ir);
    check("R10 irq on tx drain", {31'd0, ir}, 32'd1);
    @(negedge clk);
    check("R10 irq one cycle", {31'd0, irq}, 32'd0);
    busWr(4'hC, 32'h0);

    // R5 tx full, 17th write dropped
    for (int i = 0; i < 17; i++) busWr(4'h4, i);
    busRd(4'h8, d);
    check("R5 tx full status", d, 32'h08);
    for (int i = 0; i < 16; i++) begin
      check("R5 drained byte", {24'd0, txByte}, i);
      txPop(ir);
    end
    check("R5 only 16 kept", {31'd0, txValid}, 32'd0);

    // R3 rx path and R10 rx pulse
    busWr(4'hC, 32'h10);
    rxSend(8'h5A, ir);
    check("R10 irq on rx valid", {31'd0, ir}, 32'd1);
    rxSend(8'h6B, ir);
    check("R10 no irq when already valid", {31'd0, ir}, 32'd0);
    busRd(4'h0, d);
    check("R3 first byte", d, 32'h5A);
    busRd(4'h2, d);
    check("R3 second byte", d, 32'h6B);
    busRd(4'h0, d);
    check("R3 empty read zero", d, 32'h0);
    busWr(4'hC, 32'h0);
    rxSend(8'h77, ir);
    check("R10 no irq when disabled", {31'd0, ir}, 32'd0);
    busWr(4'hC, 32'h02);
    busRd(4'h8, d);
    check("R8 rx flush status", d, 32'h04);
    busRd(4'h0, d);
    check("R8 rx flushed read", d, 32'h0);

    // R6 overrun
    for (int i = 0; i < 17; i++) rxSend(8'h40 + 8'(i), ir);
    busRd(4'h8, d);
    check("R6 full with overrun", d, 32'h27);
    busRd(4'h8, d);
    check("R6 overrun cleared on read", d, 32'h07);
    for (int i = 0; i < 16; i++) begin
      busRd(4'h0, d);
      check("R6 kept byte", d, 32'h40 + i);
    end
    busRd(4'h8, d);
    check("R6 17th dropped", d, 32'h04);

    // R7 sticky errors
    @(negedge clk); frameErr = 1'b1;
    @(negedge clk); frameErr = 1'b0;
    busRd(4'h8, d);
    check("R7 frame flag", d, 32'h44);
    busRd(4'h8, d);
    check("R7 frame cleared", d, 32'h04);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = 4'h8; parityErr = 1'b1;
    #3 d = busRdata;
    @(negedge clk);
    busSel = 1'b0; parityErr = 1'b0;
    check("R7 read before parity", d, 32'h04);
    busRd(4'h8, d);
    check("R7 parity survives clear", d, 32'h84);
    busRd(4'h8, d);
    check("R7 parity cleared", d, 32'h04);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule